// File: doc/BRIEF.md
# Hardware Cursor Compositor

This block overlays a small square cursor onto a scanned-out pixel stream. Each incoming pixel carries its x/y screen coordinates and a start-of-frame marker. When the pixel falls inside the visible cursor square, the block replaces it with a composited value. Otherwise it forwards the pixel unchanged. Either way the pixel leaves on an output stream with its coordinates, and both paths take the same fixed number of cycles. The framebuffer itself is never written. The compositor only sees a copy of each pixel on its way to the display.

The cursor image is held in two banks of 32-bit words. Software fills them through a plain write port. Two compositing styles are offered:

- **Mask style:** bank 0 holds an AND pattern and bank 1 an XOR pattern.
- **Blend style:** bank 0 holds premultiplied colour, with the blend factor in the top byte.

Position, visibility and style are written to shadow registers through a separate control port. They take effect only at the next start of frame, so a cursor is never torn within a frame.

Top module: `hw_cursor_comp`

## Requirements
- R1: While rst_ni is low and after its release, px_valid_o and px_data_o are 0 and the cursor is hidden until a control write has been applied at a start of frame.
- R2: Every pixel accepted with px_valid_i=1 appears on px_valid_o exactly two clock cycles later, with px_x_o/px_y_o equal to its input coordinates, whether or not it was composited.
- R3: A pixel outside the cursor square, or any pixel while the applied visibility is 0, leaves with px_data_o equal to px_data_i.
- R4: Mask style (ctl_mode_i=0): output = (pixel AND bank0[23:0]) XOR bank1[23:0].
- R5: Blend style (ctl_mode_i=1): with a = bank0[31:24], each 8-bit channel (red 23:16, green 15:8, blue 7:0) is cursor channel + floor(pixel channel * (255 - a) / 255).
- R6: In blend style a channel sum above 255 saturates to 255.
- R7: Control writes (position, visibility, style) take effect from the first pixel marked with px_sof_i=1 after the write, including that pixel. Pixels before it use the previous settings.
- R8: The cursor square covers x in [pos_x, pos_x+16) and y in [pos_y, pos_y+16). The image word for offset (dx,dy) is at address dy*16+dx.
- R9: A cycle with px_valid_i=0 produces px_valid_o=0 two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctl_we_i | input | 1 | Load shadow control registers |
| ctl_x_i | input | 12 | Cursor left edge |
| ctl_y_i | input | 12 | Cursor top edge |
| ctl_vis_i | input | 1 | Cursor visible |
| ctl_mode_i | input | 1 | 0 mask style, 1 blend style |
| img_we_i | input | 1 | Cursor image write strobe |
| img_bank_i | input | 1 | 0 colour/AND bank, 1 XOR bank |
| img_addr_i | input | 8 | Image word address dy*16+dx |
| img_data_i | input | 32 | Image word |
| px_valid_i | input | 1 | Input pixel valid |
| px_sof_i | input | 1 | Input pixel is first of a frame |
| px_x_i | input | 12 | Input pixel x |
| px_y_i | input | 12 | Input pixel y |
| px_data_i | input | 24 | Input RGB pixel |
| px_valid_o | output | 1 | Output pixel valid |
| px_x_o | output | 12 | Output pixel x |
| px_y_o | output | 12 | Output pixel y |
| px_data_o | output | 24 | Output RGB pixel |

## Verification
The assertions check on every cycle that:
- the two-cycle valid and coordinate delay holds;
- a pixel that missed the cursor leaves with its data unchanged;
- the applied control state moves only on a start-of-frame pixel.

The arithmetic of the mask and blend styles, saturation, square bounds and image addressing can only be shown by the bench's scenarios with known image words and hand-derived results. The same holds for the exact frame at which a control write becomes visible.

// File: rtl/hw_cursor_pkg.sv
package hw_cursor_pkg;
  typedef enum logic {
    CUR_MASK  = 1'b0,
    CUR_ALPHA = 1'b1
  } cur_mode_e;
endpackage

// File: rtl/cursor_ctl.sv
module cursor_ctl
  import hw_cursor_pkg::*;
#(
  parameter int X_W = 12,
  parameter int Y_W = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ctl_we_i,
  input  logic [X_W-1:0] ctl_x_i,
  input  logic [Y_W-1:0] ctl_y_i,
  input  logic           ctl_vis_i,
  input  cur_mode_e      ctl_mode_i,
  input  logic           frame_go_i,
  output logic [X_W-1:0] eff_x_o,
  output logic [Y_W-1:0] eff_y_o,
  output logic           eff_vis_o,
  output cur_mode_e      eff_mode_o,
  output logic [X_W-1:0] act_x_o,
  output logic           act_vis_o
);
  logic [X_W-1:0] sh_x, ac_x;
  logic [Y_W-1:0] sh_y, ac_y;
  logic           sh_vis, ac_vis;
  cur_mode_e      sh_mode, ac_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_x <= '0; sh_y <= '0; sh_vis <= 1'b0; sh_mode <= CUR_MASK;
    end else if (ctl_we_i) begin
      sh_x <= ctl_x_i; sh_y <= ctl_y_i; sh_vis <= ctl_vis_i; sh_mode <= ctl_mode_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ac_x <= '0; ac_y <= '0; ac_vis <= 1'b0; ac_mode <= CUR_MASK;
    end else if (frame_go_i) begin
      ac_x <= sh_x; ac_y <= sh_y; ac_vis <= sh_vis; ac_mode <= sh_mode;
    end
  end

  // the start-of-frame pixel already sees the new settings
  always_comb begin
    eff_x_o    = frame_go_i ? sh_x    : ac_x;
    eff_y_o    = frame_go_i ? sh_y    : ac_y;
    eff_vis_o  = frame_go_i ? sh_vis  : ac_vis;
    eff_mode_o = frame_go_i ? sh_mode : ac_mode;
  end

  assign act_x_o   = ac_x;
  assign act_vis_o = ac_vis;
endmodule

// File: rtl/cursor_img.sv
module cursor_img #(
  parameter int CUR_W  = 16,
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(CUR_W),
  localparam int AW    = 2 * IDX_W,
  localparam int DEPTH = CUR_W * CUR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic              bank_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [WORD_W-1:0] prim_o,
  output logic [WORD_W-1:0] xor_o
);
  logic [WORD_W-1:0] rd_q [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [WORD_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && (bank_i == b[0])) mem[waddr_i] <= wdata_i;
      rd_q[b] <= mem[raddr_i];
    end
  end

  assign prim_o = rd_q[0];
  assign xor_o  = rd_q[1];
endmodule

// File: rtl/cursor_blend.sv
module cursor_blend
  import hw_cursor_pkg::*;
#(
  parameter int CH_W = 8,
  parameter int NCH  = 3,
  localparam int PIX_W  = CH_W * NCH,
  localparam int WORD_W = PIX_W + CH_W
) (
  input  cur_mode_e         mode_i,
  input  logic              hit_i,
  input  logic [PIX_W-1:0]  bg_i,
  input  logic [WORD_W-1:0] prim_i,
  input  logic [WORD_W-1:0] xor_i,
  output logic [PIX_W-1:0]  pix_o
);
  localparam logic [CH_W-1:0] FULL = '1;
  logic [CH_W-1:0] inv_a;
  assign inv_a = FULL - prim_i[WORD_W-1 -: CH_W];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CH_W-1:0]   bg_c, cur_c, q_c, res_c;
    logic [2*CH_W-1:0] prod;
    logic [2*CH_W:0]   t;
    logic [CH_W:0]     sum;
    assign bg_c  = bg_i[c*CH_W +: CH_W];
    assign cur_c = prim_i[c*CH_W +: CH_W];
    assign prod  = bg_c * inv_a;
    // exact floor(prod / (2^CH_W - 1)) without a divider
    assign t     = {1'b0, prod} + {{(2*CH_W){1'b0}}, 1'b1}
                 + {{(CH_W+1){1'b0}}, prod[2*CH_W-1 -: CH_W]};
    assign q_c   = t[2*CH_W-1 -: CH_W];
    assign sum   = {1'b0, cur_c} + {1'b0, q_c};
    always_comb begin
      if (!hit_i)                res_c = bg_c;
      else if (mode_i == CUR_MASK) res_c = (bg_c & cur_c) ^ xor_i[c*CH_W +: CH_W];
      else                       res_c = sum[CH_W] ? FULL : sum[CH_W-1:0];
    end
    assign pix_o[c*CH_W +: CH_W] = res_c;
  end
endmodule

// File: rtl/hw_cursor_comp.sv
module hw_cursor_comp
  import hw_cursor_pkg::*;
#(
  parameter int X_W   = 12,
  parameter int Y_W   = 12,
  parameter int CUR_W = 16,
  parameter int CH_W  = 8,
  parameter int NCH   = 3,
  localparam int IDX_W  = $clog2(CUR_W),
  localparam int AW     = 2 * IDX_W,
  localparam int PIX_W  = CH_W * NCH,
  localparam int WORD_W = PIX_W + CH_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic [X_W-1:0]    ctl_x_i,
  input  logic [Y_W-1:0]    ctl_y_i,
  input  logic              ctl_vis_i,
  input  logic              ctl_mode_i,
  input  logic              img_we_i,
  input  logic              img_bank_i,
  input  logic [AW-1:0]     img_addr_i,
  input  logic [WORD_W-1:0] img_data_i,
  input  logic              px_valid_i,
  input  logic              px_sof_i,
  input  logic [X_W-1:0]    px_x_i,
  input  logic [Y_W-1:0]    px_y_i,
  input  logic [PIX_W-1:0]  px_data_i,
  output logic              px_valid_o,
  output logic [X_W-1:0]    px_x_o,
  output logic [Y_W-1:0]    px_y_o,
  output logic [PIX_W-1:0]  px_data_o
);
  localparam logic [X_W:0] CUR_WX = CUR_W[X_W:0];
  localparam logic [Y_W:0] CUR_WY = CUR_W[Y_W:0];

  logic           frame_go;
  logic [X_W-1:0] eff_x, act_x;
  logic [Y_W-1:0] eff_y;
  logic           eff_vis, act_vis;
  cur_mode_e      eff_mode;

  assign frame_go = px_valid_i && px_sof_i;

  cursor_ctl #(.X_W(X_W), .Y_W(Y_W)) u_ctl (
    .clk_i, .rst_ni,
    .ctl_we_i, .ctl_x_i, .ctl_y_i, .ctl_vis_i,
    .ctl_mode_i (cur_mode_e'(ctl_mode_i)),
    .frame_go_i (frame_go),
    .eff_x_o (eff_x), .eff_y_o (eff_y), .eff_vis_o (eff_vis), .eff_mode_o (eff_mode),
    .act_x_o (act_x), .act_vis_o (act_vis)
  );

  logic [X_W:0]  dx;
  logic [Y_W:0]  dy;
  logic          hit;
  logic [AW-1:0] raddr;

  assign dx    = {1'b0, px_x_i} - {1'b0, eff_x};
  assign dy    = {1'b0, px_y_i} - {1'b0, eff_y};
  assign hit   = px_valid_i && eff_vis && !dx[X_W] && !dy[Y_W] && (dx < CUR_WX) && (dy < CUR_WY);
  assign raddr = {dy[IDX_W-1:0], dx[IDX_W-1:0]};

  logic [WORD_W-1:0] prim_w, xor_w;

  cursor_img #(.CUR_W(CUR_W), .WORD_W(WORD_W)) u_img (
    .clk_i,
    .we_i (img_we_i), .bank_i (img_bank_i), .waddr_i (img_addr_i), .wdata_i (img_data_i),
    .raddr_i (raddr), .prim_o (prim_w), .xor_o (xor_w)
  );

  // stage 1: aligned with the image read
  logic           s1_valid, s1_hit;
  logic [X_W-1:0] s1_x;
  logic [Y_W-1:0] s1_y;
  logic [PIX_W-1:0] s1_data;
  cur_mode_e      s1_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0; s1_hit <= 1'b0; s1_x <= '0; s1_y <= '0;
      s1_data <= '0; s1_mode <= CUR_MASK;
    end else begin
      s1_valid <= px_valid_i;
      s1_hit   <= hit;
      s1_x     <= px_x_i;
      s1_y     <= px_y_i;
      s1_data  <= px_data_i;
      s1_mode  <= eff_mode;
    end
  end

  logic [PIX_W-1:0] comp;

  cursor_blend #(.CH_W(CH_W), .NCH(NCH)) u_blend (
    .mode_i (s1_mode), .hit_i (s1_hit), .bg_i (s1_data),
    .prim_i (prim_w), .xor_i (xor_w), .pix_o (comp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      px_valid_o <= 1'b0; px_x_o <= '0; px_y_o <= '0; px_data_o <= '0;
    end else begin
      px_valid_o <= s1_valid;
      px_x_o     <= s1_x;
      px_y_o     <= s1_y;
      px_data_o  <= s1_valid ? comp : '0;
    end
  end
endmodule

// File: rtl/hw_cursor_chk.sv
module hw_cursor_chk #(
  parameter int X_W   = 12,
  parameter int Y_W   = 12,
  parameter int PIX_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             px_valid_i,
  input logic             px_sof_i,
  input logic [X_W-1:0]   px_x_i,
  input logic [Y_W-1:0]   px_y_i,
  input logic [PIX_W-1:0] px_data_i,
  input logic             px_valid_o,
  input logic [X_W-1:0]   px_x_o,
  input logic [Y_W-1:0]   px_y_o,
  input logic [PIX_W-1:0] px_data_o,
  input logic             s1_hit,
  input logic             act_vis,
  input logic [X_W-1:0]   act_x
);
  // R2 R9
  valid_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    px_valid_o == $past(px_valid_i, 2));

  // R2
  coord_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    px_valid_o |-> (px_x_o == $past(px_x_i, 2)) && (px_y_o == $past(px_y_i, 2)));

  // R3
  pass_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (px_valid_o && !$past(s1_hit)) |-> px_data_o == $past(px_data_i, 2));

  // R7
  frame_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(px_valid_i && px_sof_i) |=> $stable(act_vis) && $stable(act_x));

  // R1
  reset_idle_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !px_valid_o && (px_data_o == '0));
endmodule

bind hw_cursor_comp hw_cursor_chk #(.X_W(X_W), .Y_W(Y_W), .PIX_W(PIX_W)) u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni),
  .px_valid_i (px_valid_i), .px_sof_i (px_sof_i), .px_x_i (px_x_i), .px_y_i (px_y_i),
  .px_data_i (px_data_i), .px_valid_o (px_valid_o), .px_x_o (px_x_o), .px_y_o (px_y_o),
  .px_data_o (px_data_o), .s1_hit (s1_hit), .act_vis (act_vis), .act_x (act_x)
);

// File: tb/hw_cursor_comp_tb.sv
module hw_cursor_comp_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic        ctl_we = 0, ctl_vis = 0, ctl_mode = 0;
  logic [11:0] ctl_x = 0, ctl_y = 0;
  logic        img_we = 0, img_bank = 0;
  logic [7:0]  img_addr = 0;
  logic [31:0] img_data = 0;
  logic        v_i = 0, sof_i = 0;
  logic [11:0] x_i = 0, y_i = 0;
  logic [23:0] d_i = 0;
  logic        v_o;
  logic [11:0] x_o, y_o;
  logic [23:0] d_o;

  hw_cursor_comp u_dut (
    .clk_i (clk), .rst_ni (rst_ni),
    .ctl_we_i (ctl_we), .ctl_x_i (ctl_x), .ctl_y_i (ctl_y), .ctl_vis_i (ctl_vis),
    .ctl_mode_i (ctl_mode),
    .img_we_i (img_we), .img_bank_i (img_bank), .img_addr_i (img_addr), .img_data_i (img_data),
    .px_valid_i (v_i), .px_sof_i (sof_i), .px_x_i (x_i), .px_y_i (y_i), .px_data_i (d_i),
    .px_valid_o (v_o), .px_x_o (x_o), .px_y_o (y_o), .px_data_o (d_o)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_img(input logic bank, input logic [7:0] a, input logic [31:0] w);
    @(negedge clk);
    img_we = 1; img_bank = bank; img_addr = a; img_data = w;
    @(negedge clk);
    img_we = 0;
  endtask

  task automatic cfg(input logic mode, input logic [11:0] x, input logic [11:0] y, input logic vis);
    @(negedge clk);
    ctl_we = 1; ctl_mode = mode; ctl_x = x; ctl_y = y; ctl_vis = vis;
    @(negedge clk);
    ctl_we = 0;
  endtask

  // drives one pixel; returns one negedge after it was accepted
  task automatic send(input logic sof, input logic [11:0] x, input logic [11:0] y, input logic [23:0] d);
    @(negedge clk);
    v_i = 1; sof_i = sof; x_i = x; y_i = y; d_i = d;
    @(negedge clk);
    v_i = 0; sof_i = 0;
  endtask

  task automatic px_check(input string req, input logic sof, input logic [11:0] x,
                          input logic [11:0] y, input logic [23:0] d, input logic [23:0] exp);
    send(sof, x, y, d);
    @(negedge clk);
    check(req, {8'd0, d_o}, {8'd0, exp});
  endtask

  // {mode, x, y, pixel in, expected}; cursor at (32,20), visible
  localparam int NV = 12;
  localparam logic [72:0] VEC [NV] = '{
    {1'b1, 12'd32, 12'd20, 24'hFFFFFF, 24'hBF9F8F},  // R5 a=128
    {1'b1, 12'd32, 12'd20, 24'h000000, 24'h402010},  // R5
    {1'b1, 12'd33, 12'd21, 24'hABCDEF, 24'h112233},  // R5 a=255
    {1'b1, 12'd47, 12'd35, 24'h123456, 24'h123456},  // R5 R8 a=0 corner
    {1'b1, 12'd48, 12'd20, 24'h777777, 24'h777777},  // R8 R3 right of square
    {1'b1, 12'd31, 12'd20, 24'h010203, 24'h010203},  // R8 R3 left of square
    {1'b0, 12'd32, 12'd20, 24'hFFFFFF, 24'h4020EF},  // R4
    {1'b0, 12'd47, 12'd35, 24'h5A5A5A, 24'hFFFFFF},  // R4 R8
    {1'b0, 12'd32, 12'd21, 24'h123456, 24'h120056},  // R4 R8 row stride
    {1'b0, 12'd33, 12'd21, 24'hFFFFFF, 24'h11DD33},  // R4
    {1'b1, 12'd32, 12'd36, 24'h445566, 24'h445566},  // R8 below square
    {1'b1, 12'd33, 12'd20, 24'hFFFFFF, 24'hFFFFFF}   // R6 saturation
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1", {31'd0, v_o}, 32'd0);
    check("R1", {8'd0, d_o}, 32'd0);
    rst_ni = 1;

    for (int a = 0; a < 256; a++) begin
      wr_img(1'b0, a[7:0], 32'd0);
      wr_img(1'b1, a[7:0], 32'd0);
    end
    wr_img(0, 8'd0,   32'h80402010); wr_img(1, 8'd0,   32'h000000FF);
    wr_img(0, 8'd1,   32'h10FFFFFF);
    wr_img(0, 8'd16,  32'h00FF00FF);
    wr_img(0, 8'd17,  32'hFF112233); wr_img(1, 8'd17,  32'h0000FF00);
    wr_img(1, 8'd255, 32'h00FFFFFF);

    // R1 hidden before any control write applied
    px_check("R1", 1'b1, 12'd0, 12'd0, 24'h00FFAA, 24'h00FFAA);
    px_check("R1", 1'b0, 12'd0, 12'd0, 24'hABCDEF, 24'hABCDEF);

    for (int i = 0; i < NV; i++) begin
      cfg(VEC[i][72], 12'd32, 12'd20, 1'b1);
      send(1'b1, 12'd0, 12'd0, 24'd0);
      px_check($sformatf("vector %0d", i), 1'b0, VEC[i][71:60], VEC[i][59:48],
               VEC[i][47:24], VEC[i][23:0]);
    end

    // R2 R9 latency and coordinates
    send(1'b0, 12'd40, 12'd25, 24'h010101);
    check("R2 one cycle", {31'd0, v_o}, 32'd0);
    @(negedge clk);
    check("R2 valid", {31'd0, v_o}, 32'd1);
    check("R2 x", {20'd0, x_o}, 32'd40);
    check("R2 y", {20'd0, y_o}, 32'd25);
    @(negedge clk);
    check("R9 idle", {31'd0, v_o}, 32'd0);

    // R7 hide takes effect only at start of frame
    cfg(1'b1, 12'd32, 12'd20, 1'b1);
    send(1'b1, 12'd0, 12'd0, 24'd0);
    cfg(1'b1, 12'd32, 12'd20, 1'b0);
    px_check("R7 before sof", 1'b0, 12'd32, 12'd20, 24'hFFFFFF, 24'hBF9F8F);
    px_check("R7 on sof", 1'b1, 12'd32, 12'd20, 24'hFFFFFF, 24'hFFFFFF);
    px_check("R3 hidden", 1'b0, 12'd32, 12'd20, 24'h000000, 24'h000000);

    // R7 R8 move and show
    cfg(1'b1, 12'd100, 12'd100, 1'b1);
    px_check("R7 old pos", 1'b0, 12'd100, 12'd100, 24'hFFFFFF, 24'hFFFFFF);
    px_check("R7 R8 new pos", 1'b1, 12'd100, 12'd100, 24'hFFFFFF, 24'hBF9F8F);
    px_check("R8 old spot", 1'b0, 12'd32, 12'd20, 24'h000000, 24'h000000);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule